// File: doc/BRIEF.md
# Three-Slot Pool Buffer

This block passes reference data from a producer to a consumer without ever stalling either of them. It holds three data slots and three 2-bit slot pointers: the slot the producer will fill next, the slot holding the newest finished datum, and the slot the consumer is reading. Both sides share one clock. Each side runs operations that last several cycles, and the two sides' operations may overlap freely.

A write starts with `wr_start`. Any `wr_valid` beat during the write stores `wr_data` into the write slot, and `wr_commit` publishes that slot as the newest one. At the same edge the block picks the next write slot: the only slot that is neither the newest nor the one being read. A read starts with `rd_start`, which captures the newest slot as the reading slot. The read ends with `rd_finish`. A reader may see the same datum again, or miss writes that came in between. It always gets a complete datum, never a mix of two writes.

No port has back-pressure. Nothing ever tells a side to wait, and no input ever needs a ready signal, because a write never targets the slot that is being read. A small index arbiter orders the reader's capture against the writer's publish when both happen in the same cycle. The reader goes first.

Top module: `pool3_buffer`

## Requirements
- R1: After reset, `wr_slot` is 1 and `rd_slot` is 2. A read before any write returns the parameter `INIT_VALUE`. Slot indices are 2-bit codes 1, 2 and 3.
- R2: A read that starts in a cycle after a write's commit returns the last `wr_data` stored by that write, unless a later write has committed since.
- R3: After a commit with no read starting in the same cycle, `wr_slot` is the committed slot XOR `rd_slot`. That is the third code. `wr_slot` never equals `rd_slot`.
- R4: While a read is active, `rd_data` and `rd_slot` hold steady, even while the writer stores and commits.
- R5: Two reads with no commit between them return the same value.
- R6: When several writes commit between two reads, the later read returns the value of the newest commit only.
- R7: When `rd_start` and `wr_commit` are accepted in the same cycle, the read captures the previously newest slot and value. The new `wr_slot` is the committing slot XOR that previously newest slot.
- R8: These inputs have no effect: `wr_valid` and `wr_commit` outside a write, `wr_start` during a write, `rd_finish` outside a read, and `rd_start` during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Begin a write (ignored while writing) |
| wr_valid | input | 1 | Store `wr_data` into the write slot this cycle |
| wr_data | input | DW | Write data |
| wr_commit | input | 1 | Publish the write slot as newest; ends the write |
| wr_busy | output | 1 | A write is in progress |
| wr_slot | output | 2 | Slot index the next or current write targets |
| rd_start | input | 1 | Begin a read (ignored while reading) |
| rd_finish | input | 1 | End the current read |
| rd_valid | output | 1 | A read is in progress; `rd_data` is usable |
| rd_data | output | DW | Contents of the reading slot |
| rd_slot | output | 2 | Slot index being read |

## Verification
The bench builds the block with DW = 16 and INIT_VALUE = 16'hA5A5. That initial value lies outside every written value, so a read that wrongly lands on the untouched reset slot is visible. With three slots, a handful of commits cycles the pointers through every ordering, including the same-cycle capture and publish. Long reads that overlap several commits cover the case where the writer must keep rotating between only two free slots.

// File: rtl/pool3_pkg.sv
package pool3_pkg;
  localparam int NSLOT = 3;
  localparam int IDXW  = 2;

  typedef logic [IDXW-1:0] slot_idx_t;

  localparam slot_idx_t SLOT_ONE   = 2'd1;
  localparam slot_idx_t SLOT_TWO   = 2'd2;
  localparam slot_idx_t SLOT_THREE = 2'd3;

  // The codes 1, 2 and 3 XOR pairwise to the remaining code.
  function automatic slot_idx_t other_slot(input slot_idx_t a, input slot_idx_t b);
    return a ^ b;
  endfunction
endpackage

// File: rtl/pool3_busy_track.sv
module pool3_busy_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  output logic start_acc_o,
  output logic stop_acc_o,
  output logic busy_o
);
  logic busy_q;

  assign start_acc_o = start_i && !busy_q;
  assign stop_acc_o  = stop_i && busy_q;
  assign busy_o      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           busy_q <= 1'b0;
    else if (start_acc_o) busy_q <= 1'b1;
    else if (stop_acc_o)  busy_q <= 1'b0;
  end

  // R8
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_i) |=> !busy_q);
endmodule

// File: rtl/pool3_index_arb.sv
module pool3_index_arb
  import pool3_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd_req_i,
  input  logic      wr_req_i,
  output slot_idx_t next_o,
  output slot_idx_t read_o
);
  slot_idx_t next_q, last_q, read_q;
  slot_idx_t read_mid, next_d, last_d;

  // The reader is granted first; the writer's choice sees the updated read pointer.
  always_comb begin
    read_mid = rd_req_i ? last_q : read_q;
    next_d   = next_q;
    last_d   = last_q;
    if (wr_req_i) begin
      last_d = next_q;
      next_d = other_slot(next_q, read_mid);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= SLOT_ONE;
      last_q <= SLOT_TWO;
      read_q <= SLOT_TWO;
    end else begin
      next_q <= next_d;
      last_q <= last_d;
      read_q <= read_mid;
    end
  end

  assign next_o = next_q;
  assign read_o = read_q;

  // R3
  idx_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (next_q != read_q) && (next_q != last_q) && (next_q != 2'd0)
    && (last_q != 2'd0) && (read_q != 2'd0));

  // R7
  same_cycle_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && wr_req_i) |=> (read_q == $past(last_q)) && (last_q == $past(next_q)));

  // R5
  latest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req_i |=> $stable(last_q));
endmodule

// File: rtl/pool3_slot_store.sv
module pool3_slot_store
  import pool3_pkg::*;
#(
  parameter int             DW         = 16,
  parameter logic [DW-1:0]  INIT_VALUE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  slot_idx_t     widx_i,
  input  logic [DW-1:0] wdata_i,
  input  slot_idx_t     ridx_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] slot_q [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam slot_idx_t MY_IDX = slot_idx_t'(g + 1);
    localparam logic [DW-1:0] RST_VAL = (MY_IDX == SLOT_TWO) ? INIT_VALUE : '0;
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         q <= RST_VAL;
      else if (we_i && widx_i == MY_IDX)  q <= wdata_i;
    end
    assign slot_q[g] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NSLOT; i++)
      if (ridx_i == slot_idx_t'(i + 1)) rdata_o = slot_q[i];
  end
endmodule

// File: rtl/pool3_buffer.sv
module pool3_buffer
  import pool3_pkg::*;
#(
  parameter int            DW         = 16,
  parameter logic [DW-1:0] INIT_VALUE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_start,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_commit,
  output logic          wr_busy,
  output logic [1:0]    wr_slot,
  input  logic          rd_start,
  input  logic          rd_finish,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [1:0]    rd_slot
);
  logic wr_start_acc, wr_commit_acc, wr_active, wr_we;
  logic rd_start_acc, rd_finish_acc;
  slot_idx_t next_idx, read_idx;

  pool3_busy_track u_wr_track (
    .clk(clk), .rst_n(rst_n), .start_i(wr_start), .stop_i(wr_commit),
    .start_acc_o(wr_start_acc), .stop_acc_o(wr_commit_acc), .busy_o(wr_busy)
  );

  pool3_busy_track u_rd_track (
    .clk(clk), .rst_n(rst_n), .start_i(rd_start), .stop_i(rd_finish),
    .start_acc_o(rd_start_acc), .stop_acc_o(rd_finish_acc), .busy_o(rd_valid)
  );

  pool3_index_arb u_arb (
    .clk(clk), .rst_n(rst_n), .rd_req_i(rd_start_acc), .wr_req_i(wr_commit_acc),
    .next_o(next_idx), .read_o(read_idx)
  );

  assign wr_active = wr_busy || wr_start_acc;
  assign wr_we     = wr_valid && wr_active;

  pool3_slot_store #(.DW(DW), .INIT_VALUE(INIT_VALUE)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(wr_we), .widx_i(next_idx), .wdata_i(wr_data),
    .ridx_i(read_idx), .rdata_o(rd_data)
  );

  assign wr_slot = next_idx;
  assign rd_slot = read_idx;

  // R3
  no_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_we && rd_valid) |-> (wr_slot != rd_slot));

  // R4
  rd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid) && !$past(rd_finish_acc)) |-> $stable(rd_data));

  // R8
  rd_slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_finish_acc) |=> $stable(rd_slot));

  // R8
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_busy && !wr_start) |=> $stable(wr_slot));
endmodule

// File: tb/pool3_buffer_bench.sv
`timescale 1ns/1ps
module pool3_buffer_bench;
  localparam int DW = 16;
  localparam logic [DW-1:0] INIT = 16'hA5A5;
  localparam int NVEC = 8;
  localparam logic [DW-1:0] VEC [NVEC] = '{16'h0001, 16'h1234, 16'hBEEF, 16'h0F0F,
                                           16'h7777, 16'hC001, 16'h5A5A, 16'hFFFF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_start = 0, wr_valid = 0, wr_commit = 0, rd_start = 0, rd_finish = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_busy, rd_valid;
  logic [1:0] wr_slot, rd_slot;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int m_n, m_l, m_r;
  logic [DW-1:0] m_latest;
  logic [DW-1:0] got;

  always #2.5 clk = ~clk;

  pool3_buffer #(.DW(DW), .INIT_VALUE(INIT)) u_pool3_buffer (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_commit(wr_commit), .wr_busy(wr_busy), .wr_slot(wr_slot),
    .rd_start(rd_start), .rd_finish(rd_finish), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_slot(rd_slot)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_write(input logic [DW-1:0] v);
    wr_start = 1; wr_valid = 1; wr_data = v;
    tick();
    wr_start = 0; wr_valid = 0; wr_commit = 1;
    tick();
    wr_commit = 0;
    m_l = m_n; m_n = m_n ^ m_r; m_latest = v;
  endtask

  task automatic do_read(output logic [DW-1:0] v);
    rd_start = 1;
    tick();
    rd_start = 0;
    m_r = m_l;
    v = rd_data;
    rd_finish = 1;
    tick();
    rd_finish = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_n = 1; m_l = 2; m_r = 2; m_latest = INIT;
    tick(); tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 wr_slot", DW'(wr_slot), 16'd1);
    chk("R1 rd_slot", DW'(rd_slot), 16'd2);
    chk("R1 rd_valid", DW'(rd_valid), 16'd0);
    do_read(got);
    chk("R1 first read", got, INIT);

    // R2 R3 vector table walk
    for (int i = 0; i < NVEC; i++) begin
      do_write(VEC[i]);
      chk("R3 wr_slot after commit", DW'(wr_slot), DW'(m_n));
      checks++;
      if (wr_slot == rd_slot) begin
        errors++;
        $display("FAIL R3 collide actual=%0d expected!=%0d", wr_slot, rd_slot);
      end
      if (i % 2 == 0) begin
        do_read(got);
        chk("R2 read after commit", got, VEC[i]);
        chk("R2 rd_slot", DW'(rd_slot), DW'(m_r));
      end
    end

    // R5 re-read
    do_read(got);
    chk("R5 first", got, m_latest);
    do_read(got);
    chk("R5 reread", got, m_latest);

    // R6 skipped writes
    do_write(16'h1111); do_write(16'h2222); do_write(16'h3333);
    do_read(got);
    chk("R6 newest only", got, 16'h3333);

    // R4 long read across commits
    rd_start = 1; tick(); rd_start = 0; m_r = m_l;
    got = rd_data;
    for (int k = 0; k < 4; k++) begin
      wr_start = 1; wr_valid = 1; wr_data = 16'h4000 + DW'(k);
      tick();
      chk("R4 data steady", rd_data, got);
      checks++;
      if (wr_slot == rd_slot) begin
        errors++;
        $display("FAIL R4 collide actual=%0d expected!=%0d", wr_slot, rd_slot);
      end
      wr_start = 0; wr_valid = 0; wr_commit = 1;
      tick();
      wr_commit = 0;
      m_l = m_n; m_n = m_n ^ m_r; m_latest = 16'h4000 + DW'(k);
      chk("R4 data steady after commit", rd_data, got);
      chk("R4 wr_slot", DW'(wr_slot), DW'(m_n));
    end
    // R8 rd_start during read ignored
    rd_start = 1; tick(); rd_start = 0;
    chk("R8 restart ignored data", rd_data, got);
    chk("R8 restart ignored slot", DW'(rd_slot), DW'(m_r));
    rd_finish = 1; tick(); rd_finish = 0;
    do_read(got);
    chk("R4 after long read", got, 16'h4003);

    // R7 same-cycle capture and publish
    begin
      int old_n, old_l;
      logic [DW-1:0] old_val;
      old_n = m_n; old_l = m_l; old_val = m_latest;
      wr_start = 1; wr_valid = 1; wr_data = 16'h7E7E;
      tick();
      wr_start = 0; wr_valid = 0; wr_commit = 1; rd_start = 1;
      tick();
      wr_commit = 0; rd_start = 0;
      m_r = old_l; m_l = old_n; m_n = old_n ^ old_l; m_latest = 16'h7E7E;
      chk("R7 read gets previous", rd_data, old_val);
      chk("R7 rd_slot", DW'(rd_slot), DW'(old_l));
      chk("R7 wr_slot", DW'(wr_slot), DW'(old_n ^ old_l));
      rd_finish = 1; tick(); rd_finish = 0;
      do_read(got);
      chk("R7 next read new value", got, 16'h7E7E);
    end

    // R8 stray inputs outside operations
    begin
      int slot_before;
      slot_before = wr_slot;
      wr_valid = 1; wr_data = 16'hDEAD; wr_commit = 1;
      tick();
      wr_valid = 0; wr_commit = 0;
      chk("R8 stray commit wr_slot", DW'(wr_slot), DW'(slot_before));
      rd_finish = 1; tick(); rd_finish = 0;
      chk("R8 stray finish rd_valid", DW'(rd_valid), 16'd0);
      do_read(got);
      chk("R8 stray write no effect", got, m_latest);
      // wr_start during a write ignored: write keeps its slot
      wr_start = 1; wr_valid = 1; wr_data = 16'h0A0A; tick();
      slot_before = wr_slot;
      wr_valid = 0; tick();
      wr_start = 0;
      chk("R8 restart write slot", DW'(wr_slot), DW'(slot_before));
      wr_commit = 1; tick(); wr_commit = 0;
      m_l = m_n; m_n = m_n ^ m_r; m_latest = 16'h0A0A;
      do_read(got);
      chk("R8 write after restart", got, 16'h0A0A);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule